// File: doc/BRIEF.md
# Multi-Register Transfer Address Sequencer

This block turns a single block-transfer request into a series of single-word memory transfers. A request carries a base address, a 16-bit mask that picks any subset of the sixteen architectural registers, an addressing mode, a read/write select and a flag asking for the base to be updated. The sequencer then emits one transfer for each selected register. Each transfer carries the register index and the word address, and the sequencer offers it on a valid/ready interface.

Registers always leave in rising index order, whatever the direction of the mode. The mode only decides where the lowest-indexed register lands and what the updated base becomes. A descending stack push uses the decrement-before mode and the matching pop uses increment-after, and each word moves the pointer by four bytes. When the last transfer has completed, a one-cycle done pulse presents the updated base together with a write strobe.

Requests enter through a valid/ready pair. A request is accepted only in a cycle where `start_ready` is high, and `start_ready` stays low from acceptance until the done pulse. Transfers obey the usual back-pressure rule. While `xfer_valid` is high and `xfer_ready` is low, the index, address and direction are held, and the sequencer advances only on a cycle where both are high.

Top module: `multi_xfer_addr_seq`

## Requirements
- R1: After reset, `start_ready` is 1 and both `xfer_valid` and `done` are 0.
- R2: An accepted request yields exactly one transfer per set mask bit, in ascending index order, with `xfer_reg` equal to the bit position (bit 0 is register 0).
- R3: With N set bits, `mode` 2'b00 (increment-after) starts at base, 2'b01 (increment-before) at base+4, 2'b10 (decrement-after) at base-4N+4 and 2'b11 (decrement-before) at base-4N. Each later transfer is 4 above the previous one, modulo 2^32.
- R4: When writeback is requested, the done cycle shows `wb_write`=1 and a `wb_value` of base+4N for modes 2'b00/2'b01 or base-4N for modes 2'b10/2'b11.
- R5: When writeback is not requested, the done cycle shows `wb_write`=0 and a `wb_value` equal to the original base.
- R6: An all-zero mask produces no transfer, and `done` is high in the cycle right after acceptance with `wb_value` equal to base.
- R7: While `xfer_valid`=1 and `xfer_ready`=0, `xfer_valid`, `xfer_reg`, `xfer_addr` and `xfer_load` keep their values into the next cycle.
- R8: `start_ready` is 0 from the cycle after acceptance until the done cycle, and a request presented during that time is neither taken nor able to change the transfers in flight.
- R9: `done` is high for exactly one cycle, the cycle right after the final transfer handshake, and `start_ready` returns to 1 in the cycle after that.
- R10: `xfer_load` equals the `is_load` value captured with the request, for every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | A request is offered |
| start_ready | output | 1 | The sequencer is idle and will take a request |
| base_addr | input | 32 | Base address of the request |
| reg_mask | input | 16 | Selected registers, bit i selects register i |
| addr_mode | input | 2 | 00 inc-after, 01 inc-before, 10 dec-after, 11 dec-before |
| is_load | input | 1 | 1 for memory-to-register, 0 for register-to-memory |
| wb_en | input | 1 | Request an updated base |
| xfer_valid | output | 1 | A transfer is offered |
| xfer_ready | input | 1 | The memory side accepts the transfer |
| xfer_reg | output | 4 | Register index of the transfer |
| xfer_addr | output | 32 | Word address of the transfer |
| xfer_load | output | 1 | Direction of the transfer |
| done | output | 1 | One-cycle pulse at the end of a request |
| wb_write | output | 1 | Base update strobe, high with done when writeback is requested |
| wb_value | output | 32 | Updated base (or the unchanged base), valid with done |

## Verification
The hardest situation to reach from the ports is a stall on a transfer in the middle of a long run while a second request is already waiting on the start side. The bench holds `xfer_ready` low for one cycle before every handshake of a full sixteen-register push. In a directed case it also keeps `start_valid` high with a different base and mask throughout a run. It then checks that the held transfer does not move, that the waiting request is not taken, and that the addresses follow the first request to the end. A decrement-before request near address zero covers the wrap of the start address.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'b00,
    MODE_INC_BEFORE = 2'b01,
    MODE_DEC_AFTER  = 2'b10,
    MODE_DEC_BEFORE = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } state_t;

endpackage

// File: rtl/mxs_bit_count.sv
module mxs_bit_count #(
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] bits,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count = count + CNT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/mxs_low_pick.sv
module mxs_low_pick #(
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits,
  output logic [IDX_W-1:0] index,
  output logic [WIDTH-1:0] onehot
);
  // below[i] is set when some bit under position i is set
  logic [WIDTH:0] below;

  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_chain
      assign below[g+1]  = below[g] | bits[g];
      assign onehot[g]   = bits[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    index = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (onehot[i]) index = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mxs_addr_plan.sv
module mxs_addr_plan
  import mxs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W     = $clog2(NUM_REGS + 1),
  localparam int SHIFT     = $clog2(WORD_BYTES)
) (
  input  logic [ADDR_W-1:0] base,
  input  mode_t             mode,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_base
);
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] step;

  assign span = ADDR_W'(count) << SHIFT;
  assign step = ADDR_W'(WORD_BYTES);

  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:  first_addr = base;
      MODE_INC_BEFORE: first_addr = base + step;
      MODE_DEC_AFTER:  first_addr = base - span + step;
      default:         first_addr = base - span;
    endcase
    final_base = mode[1] ? (base - span) : (base + span);
  end
endmodule

// File: rtl/multi_xfer_addr_seq.sv
module multi_xfer_addr_seq
  import mxs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int CNT_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [NUM_REGS-1:0] reg_mask,
  input  logic [1:0]          addr_mode,
  input  logic                is_load,
  input  logic                wb_en,
  output logic                xfer_valid,
  input  logic                xfer_ready,
  output logic [IDX_W-1:0]    xfer_reg,
  output logic [ADDR_W-1:0]   xfer_addr,
  output logic                xfer_load,
  output logic                done,
  output logic                wb_write,
  output logic [ADDR_W-1:0]   wb_value
);
  state_t              state_q;
  logic [NUM_REGS-1:0] pending_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [ADDR_W-1:0]   base_q;
  logic [ADDR_W-1:0]   new_base_q;
  logic                load_q;
  logic                wb_q;

  logic [CNT_W-1:0]    sel_count;
  logic [ADDR_W-1:0]   plan_first;
  logic [ADDR_W-1:0]   plan_final;
  logic [IDX_W-1:0]    pick_idx;
  logic [NUM_REGS-1:0] pick_hot;
  logic [NUM_REGS-1:0] pending_next;
  logic                accept;
  logic                advance;

  mxs_bit_count #(.WIDTH(NUM_REGS)) u_count (
    .bits  (reg_mask),
    .count (sel_count)
  );

  mxs_addr_plan #(
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .WORD_BYTES (WORD_BYTES)
  ) u_plan (
    .base       (base_addr),
    .mode       (mode_t'(addr_mode)),
    .count      (sel_count),
    .first_addr (plan_first),
    .final_base (plan_final)
  );

  mxs_low_pick #(.WIDTH(NUM_REGS)) u_pick (
    .bits   (pending_q),
    .index  (pick_idx),
    .onehot (pick_hot)
  );

  assign start_ready  = (state_q == ST_IDLE);
  assign accept       = start_valid & start_ready;
  assign xfer_valid   = (state_q == ST_RUN);
  assign advance      = xfer_valid & xfer_ready;
  assign pending_next = pending_q & ~pick_hot;

  assign xfer_reg  = pick_idx;
  assign xfer_addr = addr_q;
  assign xfer_load = load_q;

  assign done     = (state_q == ST_DONE);
  assign wb_write = done & wb_q;
  assign wb_value = wb_q ? new_base_q : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pending_q  <= '0;
      addr_q     <= '0;
      base_q     <= '0;
      new_base_q <= '0;
      load_q     <= 1'b0;
      wb_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pending_q  <= reg_mask;
            addr_q     <= plan_first;
            base_q     <= base_addr;
            new_base_q <= plan_final;
            load_q     <= is_load;
            wb_q       <= wb_en;
            state_q    <= (reg_mask == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (advance) begin
            pending_q <= pending_next;
            addr_q    <= addr_q + ADDR_W'(WORD_BYTES);
            if (pending_next == '0) state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mxs_checker.sv
module mxs_checker #(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic [ADDR_W-1:0] base_addr,
  input logic              is_load,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [IDX_W-1:0]  xfer_reg,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              xfer_load,
  input logic              done,
  input logic              wb_write,
  input logic [ADDR_W-1:0] wb_value
);
  logic [ADDR_W-1:0] base_seen;
  logic              load_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_seen <= '0;
      load_seen <= 1'b0;
    end else if (start_valid && start_ready) begin
      base_seen <= base_addr;
      load_seen <= is_load;
    end
  end

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_reg) &&
                                     $stable(xfer_addr) && $stable(xfer_load)));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=>
      (!xfer_valid || (xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES))));

  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (!xfer_valid || (xfer_reg > $past(xfer_reg))));

  assert_busy_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ready && (xfer_valid || done)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && start_ready));

  assert_keep_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wb_write) |-> (wb_value == base_seen));

  assert_dir_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_load == load_seen));
endmodule

bind multi_xfer_addr_seq mxs_checker #(
  .ADDR_W     (ADDR_W),
  .NUM_REGS   (NUM_REGS),
  .WORD_BYTES (WORD_BYTES)
) u_chk (.*);

// File: tb/multi_xfer_addr_seq_test.sv
module multi_xfer_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic [1:0]  addr_mode = '0;
  logic        is_load = 1'b0;
  logic        wb_en = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr;
  logic        xfer_load;
  logic        done;
  logic        wb_write;
  logic [31:0] wb_value;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  multi_xfer_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .base_addr(base_addr), .reg_mask(reg_mask), .addr_mode(addr_mode),
    .is_load(is_load), .wb_en(wb_en), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_reg(xfer_reg), .xfer_addr(xfer_addr),
    .xfer_load(xfer_load), .done(done), .wb_write(wb_write), .wb_value(wb_value)
  );

  // stimulus and expected values: base, mask, mode, load, wb, stall, first addr, done value
  localparam int NV = 8;
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_3000,
    32'h0000_4000, 32'h2000_0100, 32'h2000_00C0, 32'h0000_5000, 32'h0000_0004};
  localparam logic [15:0] V_MASK [NV] = '{16'h0005, 16'h8001, 16'h00F0, 16'h4012,
    16'hFFFF, 16'hFFFF, 16'h0100, 16'h0007};
  localparam logic [1:0]  V_MODE [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b00, 2'b01, 2'b11};
  localparam logic [NV-1:0] V_LOAD  = 8'b1010_0101;
  localparam logic [NV-1:0] V_WB    = 8'b1011_1111;
  localparam logic [NV-1:0] V_STALL = 8'b0101_0010;
  localparam logic [31:0] V_FIRST [NV] = '{32'h0000_1000, 32'h0000_2004, 32'h0000_2FF4,
    32'h0000_3FF4, 32'h2000_00C0, 32'h2000_00C0, 32'h0000_5004, 32'hFFFF_FFF8};
  localparam logic [31:0] V_DONE [NV] = '{32'h0000_1008, 32'h0000_2008, 32'h0000_2FF0,
    32'h0000_3FF4, 32'h2000_00C0, 32'h2000_0100, 32'h0000_5000, 32'hFFFF_FFF8};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic offer(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                       input logic ld, input logic wb);
    @(negedge clk);
    chk("R8", "start_ready before offer", 32'(start_ready), 32'd1);
    start_valid = 1'b1; base_addr = b; reg_mask = m; addr_mode = md;
    is_load = ld; wb_en = wb;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  // walks the transfers of an accepted request and its done cycle
  task automatic drain(input logic [15:0] m, input logic ld, input logic [31:0] first,
                       input logic wb, input logic [31:0] final_val, input bit stall);
    logic [31:0] a = first;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        chk("R8", "start_ready while busy", 32'(start_ready), 32'd0);
        if (stall) begin
          xfer_ready = 1'b0;
          chk("R2", "valid before stall", 32'(xfer_valid), 32'd1);
          @(negedge clk);
          chk("R7", "reg held", 32'(xfer_reg), 32'(i));
          chk("R7", "addr held", xfer_addr, a);
        end
        xfer_ready = 1'b1;
        chk("R2", "valid", 32'(xfer_valid), 32'd1);
        chk("R2", "register order", 32'(xfer_reg), 32'(i));
        chk("R3", "address", xfer_addr, a);
        chk("R10", "direction", 32'(xfer_load), 32'(ld));
        @(negedge clk);
        xfer_ready = 1'b0;
        a = a + 32'd4;
      end
    end
    chk("R9", "done after last", 32'(done), 32'd1);
    chk("R2", "no extra transfer", 32'(xfer_valid), 32'd0);
    chk(wb ? "R4" : "R5", "wb_write", 32'(wb_write), 32'(wb));
    chk(wb ? "R4" : "R5", "wb_value", wb_value, final_val);
    @(negedge clk);
    chk("R9", "done one cycle", 32'(done), 32'd0);
    chk("R9", "ready again", 32'(start_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset start_ready", 32'(start_ready), 32'd1);
    chk("R1", "reset xfer_valid", 32'(xfer_valid), 32'd0);
    chk("R1", "reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", 32'(xfer_valid | done), 32'd0);

    for (int v = 0; v < NV; v++) begin
      offer(V_BASE[v], V_MASK[v], V_MODE[v], V_LOAD[v], V_WB[v]);
      drain(V_MASK[v], V_LOAD[v], V_FIRST[v], V_WB[v], V_DONE[v], V_STALL[v]);
    end

    // R6: empty mask, done in the cycle right after acceptance
    offer(32'h0000_6000, 16'h0000, 2'b01, 1'b1, 1'b1);
    chk("R6", "empty done", 32'(done), 32'd1);
    chk("R6", "empty no transfer", 32'(xfer_valid), 32'd0);
    chk("R6", "empty base kept", wb_value, 32'h0000_6000);
    @(negedge clk);
    chk("R6", "empty pulse ends", 32'(done), 32'd0);

    // R8: a second request held on the start side during a run is ignored
    @(negedge clk);
    start_valid = 1'b1; base_addr = 32'h0000_7000; reg_mask = 16'h0003;
    addr_mode = 2'b00; is_load = 1'b0; wb_en = 1'b1;
    @(negedge clk);
    base_addr = 32'h0000_9990; reg_mask = 16'hFFFF; addr_mode = 2'b11; is_load = 1'b1;
    for (int k = 0; k < 2; k++) begin
      chk("R8", "ignored start, ready low", 32'(start_ready), 32'd0);
      chk("R8", "run unchanged addr", xfer_addr, 32'h0000_7000 + 32'(4 * k));
      chk("R8", "run unchanged reg", 32'(xfer_reg), 32'(k));
      chk("R10", "direction kept", 32'(xfer_load), 32'd0);
      xfer_ready = 1'b1;
      @(negedge clk);
      xfer_ready = 1'b0;
    end
    chk("R8", "done of first request", 32'(done), 32'd1);
    chk("R4", "wb of first request", wb_value, 32'h0000_7008);
    start_valid = 1'b0;
    @(negedge clk);
    chk("R8", "nothing taken", 32'(xfer_valid | done), 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule